// File: doc/BRIEF.md
# Disk Drive Mechanism Sequencer

This block times the mechanical life of a serial magnetic disk drive: a disk being seated after insertion, the motor spinning up, the head streaming over the medium, and the head travelling back to the start after it reaches the end. Each phase lasts a parameter-set number of clock cycles. While the disk streams, the block emits a one-cycle bit tick at a fixed cell period and advances a head bit position. The read and write engines next to it use that tick to move one data bit.

Software-facing control reaches the block as a control write strobe. The strobe carries a motor-start bit and a transfer-reset bit. With transfer-reset set, the head runs to the end of the disk without data moving, because ticks are withheld from the data engines. An active-low drive status byte reports whether a disk is seated, whether the drive is ready to stream, and whether the disk is writable. All durations default to the figures of the real mechanism and can be overridden for fast tests.

Top module: `dsk_mech_seq`

## Requirements
- R1: After reset the block is idle with no disk: drv_status = 0xFD, head_pos = 0, bit_tick = 0, end_of_disk = 0.
- R2: An insert strobe, in any state, zeroes head_pos, latches wp_in and disk_bits, and enters the inserting state. While inserting, drv_status is 0xFF. The state lasts exactly INSERT_CYC cycles and then returns to idle.
- R3: A control write with ctl_motor = 1 moves idle to spin-up only when a disk is present. Without a disk, or in any other state, the bit is ignored.
- R4: Spin-up lasts exactly SPINUP_CYC cycles and then enters running. A pending transfer-reset flag survives this transition.
- R5: In running, the block steps once per SPIN cell of PER_BIT_CYC cycles, in the last cycle of each cell. bit_tick is high for that single cycle, and head_pos increments at the clock edge that closes the cell.
- R6: A control write with ctl_xreset = 1 sets the transfer-reset flag. While the flag is set, running steps still advance head_pos but bit_tick stays low.
- R7: A step that brings head_pos up to the latched length enters head-return and clears transfer-reset. end_of_disk is high while a disk is present and head_pos equals the length.
- R8: Head-return lasts exactly HRET_CYC cycles. It then enters idle, zeroes head_pos and clears transfer-reset. An insert finishing does the same.
- R9: An eject strobe, in any state, enters idle and marks the disk absent. head_pos keeps its value.
- R10: drv_status is active low, with bits 7..3 always 1. Bit 0 is low when a disk is present and the state is not inserting. Bit 1 is low when transfer-reset is clear and the state is idle or running. Bit 2 is low when a disk is present, the state is not inserting and the disk is writable.
- R11: The idle timer expiring (every IDLE_CYC cycles) changes no output.
- R12: Eject takes priority over insert, and insert over control writes and timer events. A transfer-reset write in the same cycle as a clearing event leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| insert_stb | input | 1 | One-cycle disk insertion event |
| eject_stb | input | 1 | One-cycle disk removal event |
| wp_in | input | 1 | Write-protect of the disk being inserted (1 = protected) |
| disk_bits | input | POS_W | Disk length in bits, latched at insert, at least 1 |
| ctl_wr | input | 1 | Control write strobe |
| ctl_motor | input | 1 | Motor-start bit of the control write |
| ctl_xreset | input | 1 | Transfer-reset bit of the control write |
| bit_tick | output | 1 | One-cycle pulse per data bit cell |
| head_pos | output | POS_W | Head bit position |
| end_of_disk | output | 1 | Head at the end of the present disk |
| drv_status | output | 8 | Active-low drive status byte |

## Verification
Every output is a registered state or a function of registered state. A strobe applied in one cycle therefore shows at the outputs right after the next rising edge, with one exception: bit_tick is also qualified by the same-cycle eject and insert strobes. A phase of N cycles that is entered at edge E ends at edge E+N, and a running cell's tick sits in the cycle before the edge that advances head_pos. The bench drives inputs at the falling edge and samples 2 to 3 ns later, so each sample sees the state after the preceding rising edge and the inputs of the current cycle. A cycle model in the bench advances on the same rising edges. The directed checks count falling edges from the entry edge to land on the last cycle of each phase and on the first cycle of the next.

// File: rtl/dsk_seq_pkg.sv
package dsk_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INS  = 3'd1,
    ST_SPIN = 3'd2,
    ST_RUN  = 3'd3,
    ST_HRET = 3'd4
  } drv_state_t;
endpackage

// File: rtl/dsk_interval_timer.sv
module dsk_interval_timer #(
  parameter int unsigned      CNT_W   = 24,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // A phase of N cycles loads N; the final cycle is the one holding 1.
  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dsk_head_ctr.sv
module dsk_head_ctr #(
  parameter int unsigned POS_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [POS_W-1:0] pos
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;

  assign pos_en = clr | step;

  always_comb begin
    if (clr) pos_d = '0;
    else     pos_d = pos_q + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/dsk_status_enc.sv
module dsk_status_enc
  import dsk_seq_pkg::*;
(
  input  drv_state_t  st,
  input  logic        present,
  input  logic        wprot,
  input  logic        xreset,
  output logic [7:0]  status
);
  logic seated, ready;

  assign seated = present && (st != ST_INS);
  assign ready  = !xreset && ((st == ST_RUN) || (st == ST_IDLE));

  always_comb begin
    status    = 8'hFF;
    status[0] = !seated;
    status[1] = !ready;
    status[2] = !(seated && !wprot);
  end
endmodule

// File: rtl/dsk_drive_fsm.sv
module dsk_drive_fsm
  import dsk_seq_pkg::*;
#(
  parameter int unsigned POS_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eject,
  input  logic             insert,
  input  logic             wp_in,
  input  logic [POS_W-1:0] disk_bits,
  input  logic             ctl_wr,
  input  logic             ctl_motor,
  input  logic             ctl_xreset,
  input  logic             expire,
  input  logic [POS_W-1:0] pos,
  output drv_state_t       st,
  output drv_state_t       st_nx,
  output logic             enter,
  output logic             pos_clr,
  output logic             step,
  output logic             tick,
  output logic             xreset,
  output logic             present,
  output logic             wprot,
  output logic [POS_W-1:0] len
);
  drv_state_t       st_q, st_d;
  logic             xr_q, xr_d, xr_clr;
  logic             pres_q, pres_d;
  logic             wp_q, wp_d;
  logic [POS_W-1:0] len_q, len_d;
  logic             last_bit;

  assign last_bit = ((pos + POS_W'(1)) == len_q);

  always_comb begin
    st_d    = st_q;
    pres_d  = pres_q;
    wp_d    = wp_q;
    len_d   = len_q;
    enter   = 1'b0;
    pos_clr = 1'b0;
    step    = 1'b0;
    xr_clr  = 1'b0;
    if (eject) begin
      st_d   = ST_IDLE;
      pres_d = 1'b0;
      enter  = 1'b1;
    end else if (insert) begin
      st_d    = ST_INS;
      pres_d  = 1'b1;
      wp_d    = wp_in;
      len_d   = disk_bits;
      pos_clr = 1'b1;
      enter   = 1'b1;
    end else begin
      unique case (st_q)
        ST_INS, ST_HRET: begin
          if (expire) begin
            st_d    = ST_IDLE;
            pos_clr = 1'b1;
            xr_clr  = 1'b1;
            enter   = 1'b1;
          end
        end
        ST_SPIN: begin
          if (expire) begin
            st_d  = ST_RUN;
            enter = 1'b1;
          end
        end
        ST_RUN: begin
          if (expire) begin
            step = 1'b1;
            if (last_bit) begin
              st_d   = ST_HRET;
              xr_clr = 1'b1;
              enter  = 1'b1;
            end
          end
        end
        default: begin
          if (ctl_wr && ctl_motor && pres_q) begin
            st_d  = ST_SPIN;
            enter = 1'b1;
          end
        end
      endcase
    end
    xr_d = xr_clr ? 1'b0 : xr_q;
    if (ctl_wr && ctl_xreset) xr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      xr_q   <= 1'b0;
      pres_q <= 1'b0;
      wp_q   <= 1'b1;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      xr_q   <= xr_d;
      pres_q <= pres_d;
      wp_q   <= wp_d;
      if (insert && !eject) len_q <= len_d;
    end
  end

  assign st      = st_q;
  assign st_nx   = st_d;
  assign tick    = step && !xr_q;
  assign xreset  = xr_q;
  assign present = pres_q;
  assign wprot   = wp_q;
  assign len     = len_q;
endmodule

// File: rtl/dsk_mech_seq.sv
module dsk_mech_seq
  import dsk_seq_pkg::*;
#(
  parameter int unsigned POS_W       = 20,
  parameter int unsigned PER_BIT_CYC = 56,
  parameter int unsigned INSERT_CYC  = 1600000,
  parameter int unsigned SPINUP_CYC  = 1070000,
  parameter int unsigned HRET_CYC    = 6443100,
  parameter int unsigned IDLE_CYC    = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insert_stb,
  input  logic             eject_stb,
  input  logic             wp_in,
  input  logic [POS_W-1:0] disk_bits,
  input  logic             ctl_wr,
  input  logic             ctl_motor,
  input  logic             ctl_xreset,
  output logic             bit_tick,
  output logic [POS_W-1:0] head_pos,
  output logic             end_of_disk,
  output logic [7:0]       drv_status
);
  localparam int unsigned MAX_A   = (INSERT_CYC > SPINUP_CYC) ? INSERT_CYC : SPINUP_CYC;
  localparam int unsigned MAX_B   = (HRET_CYC > IDLE_CYC) ? HRET_CYC : IDLE_CYC;
  localparam int unsigned MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC = (MAX_C > PER_BIT_CYC) ? MAX_C : PER_BIT_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             rs1_q, rst_s_n;
  drv_state_t       st_q, st_nx;
  logic             enter, pos_clr, step, tick, expire, tmr_load;
  logic             xreset_q, present_q, wprot_q;
  logic [POS_W-1:0] len_q, pos;
  logic [CNT_W-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_s_n <= rs1_q;
    end
  end

  always_comb begin
    unique case (st_nx)
      ST_INS:  tmr_val = CNT_W'(INSERT_CYC);
      ST_SPIN: tmr_val = CNT_W'(SPINUP_CYC);
      ST_RUN:  tmr_val = CNT_W'(PER_BIT_CYC);
      ST_HRET: tmr_val = CNT_W'(HRET_CYC);
      default: tmr_val = CNT_W'(IDLE_CYC);
    endcase
  end

  assign tmr_load = enter | expire;

  dsk_interval_timer #(.CNT_W(CNT_W), .RST_VAL(CNT_W'(IDLE_CYC))) u_timer (
    .clk(clk), .rst_n(rst_s_n), .load(tmr_load), .load_val(tmr_val), .expire(expire)
  );

  dsk_drive_fsm #(.POS_W(POS_W)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .eject(eject_stb), .insert(insert_stb),
    .wp_in(wp_in), .disk_bits(disk_bits), .ctl_wr(ctl_wr), .ctl_motor(ctl_motor),
    .ctl_xreset(ctl_xreset), .expire(expire), .pos(pos), .st(st_q), .st_nx(st_nx),
    .enter(enter), .pos_clr(pos_clr), .step(step), .tick(tick), .xreset(xreset_q),
    .present(present_q), .wprot(wprot_q), .len(len_q)
  );

  dsk_head_ctr #(.POS_W(POS_W)) u_head (
    .clk(clk), .rst_n(rst_s_n), .clr(pos_clr), .step(step), .pos(pos)
  );

  dsk_status_enc u_stat (
    .st(st_q), .present(present_q), .wprot(wprot_q), .xreset(xreset_q), .status(drv_status)
  );

  assign bit_tick    = tick;
  assign head_pos    = pos;
  assign end_of_disk = present_q && (pos == len_q);
endmodule

// File: rtl/dsk_mech_seq_chk.sv
module dsk_mech_seq_chk
  import dsk_seq_pkg::*;
#(
  parameter int unsigned POS_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eject_stb,
  input logic             insert_stb,
  input logic             ctl_wr,
  input logic             ctl_motor,
  input logic             bit_tick,
  input logic [POS_W-1:0] head_pos,
  input logic [POS_W-1:0] len,
  input drv_state_t       st,
  input logic             present,
  input logic [7:0]       drv_status
);
  // R5
  tick_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (st == ST_RUN));

  // R5
  tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> ((head_pos - $past(head_pos)) == POS_W'(1)));

  // R3
  motor_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_motor && (st == ST_IDLE) && present && !eject_stb && !insert_stb)
      |=> (st == ST_SPIN));

  // R9
  eject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eject_stb |=> ((st == ST_IDLE) && drv_status[0] && !present));

  // R2
  insert_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insert_stb && !eject_stb) |=> ((st == ST_INS) && (head_pos == '0)));

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (head_pos < len));
endmodule

bind dsk_mech_seq dsk_mech_seq_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .eject_stb(eject_stb), .insert_stb(insert_stb),
  .ctl_wr(ctl_wr), .ctl_motor(ctl_motor), .bit_tick(bit_tick), .head_pos(head_pos),
  .len(len_q), .st(st_q), .present(present_q), .drv_status(drv_status)
);

// File: tb/dsk_mech_seq_tb.sv
`timescale 1ns/1ps
module dsk_mech_seq_tb;
  localparam int PW   = 8;
  localparam int PER  = 5;
  localparam int INS  = 40;
  localparam int SPIN = 30;
  localparam int HRET = 60;
  localparam int IDL  = 17;
  localparam int M_IDLE = 0, M_INS = 1, M_SPIN = 2, M_RUN = 3, M_HRET = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins = 1'b0, ej = 1'b0, wp = 1'b0, cw = 1'b0, cm = 1'b0, cx = 1'b0;
  logic [PW-1:0] bits = 8'd4;
  logic bit_tick, end_of_disk;
  logic [PW-1:0] head_pos;
  logic [7:0] drv_status;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dsk_mech_seq #(.POS_W(PW), .PER_BIT_CYC(PER), .INSERT_CYC(INS), .SPINUP_CYC(SPIN),
                 .HRET_CYC(HRET), .IDLE_CYC(IDL)) u_dut (
    .clk(clk), .rst_n(rst_n), .insert_stb(ins), .eject_stb(ej), .wp_in(wp),
    .disk_bits(bits), .ctl_wr(cw), .ctl_motor(cm), .ctl_xreset(cx),
    .bit_tick(bit_tick), .head_pos(head_pos), .end_of_disk(end_of_disk),
    .drv_status(drv_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dur(input int s);
    case (s)
      M_INS:  return INS;
      M_SPIN: return SPIN;
      M_RUN:  return PER;
      M_HRET: return HRET;
      default: return IDL;
    endcase
  endfunction

  function automatic logic [7:0] exp_status(input int s, input logic pr, input logic w, input logic x);
    logic [7:0] v;
    v = 8'hFF;
    v[0] = !(pr && s != M_INS);
    v[1] = !(!x && (s == M_RUN || s == M_IDLE));
    v[2] = !(pr && s != M_INS && !w);
    return v;
  endfunction

  // cycle model built from the requirements
  int m_st, m_age, nst;
  logic m_xr, m_pres, m_wp, m_rs1, m_rs2, m_exp, m_ent, m_clrx;
  logic [PW-1:0] m_pos, m_len;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 <= 1'b0; m_rs2 <= 1'b0;
      m_st <= M_IDLE; m_age <= 0; m_xr <= 1'b0; m_pres <= 1'b0; m_wp <= 1'b1;
      m_pos <= '0; m_len <= '0;
    end else begin
      m_rs1 <= 1'b1; m_rs2 <= m_rs1;
      if (m_rs2) begin
        m_exp = (m_age == dur(m_st) - 1);
        nst = m_st; m_ent = 1'b0; m_clrx = 1'b0;
        if (ej) begin
          nst = M_IDLE; m_pres <= 1'b0; m_ent = 1'b1;
        end else if (ins) begin
          nst = M_INS; m_pres <= 1'b1; m_wp <= wp; m_len <= bits; m_pos <= '0; m_ent = 1'b1;
        end else if ((m_st == M_INS || m_st == M_HRET) && m_exp) begin
          nst = M_IDLE; m_pos <= '0; m_clrx = 1'b1; m_ent = 1'b1;
        end else if (m_st == M_SPIN && m_exp) begin
          nst = M_RUN; m_ent = 1'b1;
        end else if (m_st == M_RUN && m_exp) begin
          m_pos <= m_pos + 1'b1;
          if (m_pos + 1'b1 == m_len) begin nst = M_HRET; m_clrx = 1'b1; m_ent = 1'b1; end
        end else if (m_st == M_IDLE && cw && cm && m_pres) begin
          nst = M_SPIN; m_ent = 1'b1;
        end
        m_st <= nst;
        m_age <= (m_ent || m_exp) ? 0 : m_age + 1;
        if (cw && cx) m_xr <= 1'b1;
        else if (m_clrx) m_xr <= 1'b0;
      end
    end
  end

  always begin
    @(negedge clk);
    #2;
    if (m_rs2) begin
      chk("R5 tick model", bit_tick,
          (m_st == M_RUN) && (m_age == PER - 1) && !m_xr && !ej && !ins);
      chk("R5 head_pos model", head_pos, m_pos);
      chk("R10 status model", drv_status, exp_status(m_st, m_pres, m_wp, m_xr));
      chk("R7 end_of_disk model", end_of_disk, m_pres && (m_pos == m_len));
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ins(input logic w, input logic [PW-1:0] b);
    ins = 1'b1; wp = w; bits = b;
    @(negedge clk); ins = 1'b0;
  endtask

  task automatic pulse_ctl(input logic mo, input logic xr);
    cw = 1'b1; cm = mo; cx = xr;
    @(negedge clk); cw = 1'b0; cm = 1'b0; cx = 1'b0;
  endtask

  task automatic look(input string tag, input logic [7:0] st, input logic [PW-1:0] p,
                      input logic tk, input logic eod);
    #3;
    chk({tag, " status"}, drv_status, st);
    chk({tag, " head_pos"}, head_pos, p);
    chk({tag, " bit_tick"}, bit_tick, tk);
    chk({tag, " end_of_disk"}, end_of_disk, eod);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    wcyc(3); rst_n = 1'b1; wcyc(4);
    look("R1 reset", 8'hFD, 0, 0, 0);
    wcyc(1); pulse_ctl(1'b1, 1'b0);
    look("R3 motor without disk", 8'hFD, 0, 0, 0);
    wcyc(1); ej = 1'b1; ins = 1'b1; @(negedge clk); ej = 1'b0; ins = 1'b0;
    look("R12 eject beats insert", 8'hFD, 0, 0, 0);
    wcyc(1); pulse_ins(1'b0, 8'd4);
    look("R2 inserting", 8'hFF, 0, 0, 0);
    wcyc(INS - 1); look("R2 last insert cycle", 8'hFF, 0, 0, 0);
    wcyc(1); look("R2 insert done", 8'hF8, 0, 0, 0);
    wcyc(2 * IDL + 3); look("R11 idle expiry", 8'hF8, 0, 0, 0);
    wcyc(1); pulse_ctl(1'b1, 1'b0);
    look("R3 spin-up entered", 8'hFA, 0, 0, 0);
    wcyc(SPIN - 1); look("R4 last spin cycle", 8'hFA, 0, 0, 0);
    wcyc(1); look("R4 running", 8'hF8, 0, 0, 0);
    wcyc(PER - 1); look("R5 first tick", 8'hF8, 0, 1, 0);
    wcyc(1); look("R5 after tick", 8'hF8, 1, 0, 0);
    wcyc(3 * PER - 1); look("R5 last tick", 8'hF8, 3, 1, 0);
    wcyc(1); look("R7 head-return", 8'hFA, 4, 0, 1);
    wcyc(HRET - 1); look("R8 last return cycle", 8'hFA, 4, 0, 1);
    wcyc(1); look("R8 returned", 8'hF8, 0, 0, 0);
    wcyc(1); pulse_ctl(1'b0, 1'b1);
    look("R6 flag set in idle", 8'hFA, 0, 0, 0);
    wcyc(1); pulse_ctl(1'b1, 1'b0);
    wcyc(SPIN); look("R4 flag kept into run", 8'hFA, 0, 0, 0);
    wcyc(PER - 1); look("R6 tick withheld", 8'hFA, 0, 0, 0);
    wcyc(1); look("R6 head still moves", 8'hFA, 1, 0, 0);
    wcyc(3 * PER); look("R7 end under reset flag", 8'hFA, 4, 0, 1);
    wcyc(HRET); look("R8 flag cleared", 8'hF8, 0, 0, 0);
    wcyc(1); pulse_ins(1'b1, 8'd20);
    wcyc(INS); look("R2 protected disk", 8'hFC, 0, 0, 0);
    wcyc(1); pulse_ctl(1'b1, 1'b0);
    wcyc(SPIN); look("R4 protected run", 8'hFC, 0, 0, 0);
    wcyc(3 * PER); look("R5 three steps", 8'hFC, 3, 0, 0);
    ej = 1'b1; @(negedge clk); ej = 1'b0;
    look("R9 eject keeps head", 8'hFD, 3, 0, 0);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      ej   = ($urandom % 1500) == 0;
      ins  = ($urandom % 300) == 0;
      cw   = ($urandom % 25) == 0;
      cm   = $urandom % 2;
      cx   = ($urandom % 5) == 0;
      wp   = $urandom % 2;
      bits = PW'(3 + ($urandom % 30));
    end
    @(negedge clk);
    ej = 1'b0; ins = 1'b0; cw = 1'b0; cm = 1'b0; cx = 1'b0;
    wcyc(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule